// File: doc/BRIEF.md
# Priority Interrupt Controller with Single-Slave Cascade

This block collects interrupt requests from eight device lines and hands exactly one of them at a time to a processor. A rising edge on a line records a pending request. A per-line mask keeps that request out of arbitration without discarding it. A fixed-priority resolver picks the winning request, and line 0 has the highest priority. While a request may be served, the interrupt output is high.

The processor answers in two steps. An acknowledge pulse commits the choice: the winning request moves from pending to in-service and an 8-bit vector is captured, equal to the programmable base plus the line number. The vector appears on the vector output only while the vector-read input is high. A line stays in service, and keeps every line of equal or lower priority off the interrupt output, until software writes a non-specific end-of-interrupt command. That command retires the highest-priority in-service line. One request line can be marked as fed by a slave controller. When that line is acknowledged while the slave-present input is high, a select flag tells the slave to supply the vector.

Software uses a three-register write port. Address 0 writes the mask, address 1 writes the vector base and address 2 issues end-of-interrupt.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every line is masked (mask = 8'hFF), no request or in-service bit is set, the vector base is 8'h20, and the interrupt output is low. While vector-read is low, the vector output reads 8'h00.
- R2: A request bit is set only by a low-to-high change of its input line. A line that stays high after its request was acknowledged does not raise a new request until it falls and rises again.
- R3: Writing the mask (write address 0, bit n masks line n) keeps masked requests from the interrupt output while keeping them pending. Clearing the mask bit lets a held request raise the interrupt output.
- R4: Priority is fixed, with line 0 highest. On acknowledge, the captured vector is the base plus the number of the highest-priority unmasked pending line.
- R5: An acknowledge with a valid winner sets that line's in-service bit and clears its request bit. The interrupt output drops if nothing else qualifies.
- R6: A pending request is signalled only if its line has a strictly higher priority than every in-service line. A higher-priority request is still signalled, so interrupts can nest.
- R7: A write to address 2 (end of interrupt, data ignored) clears only the highest-priority set in-service bit.
- R8: A write to address 1 loads the vector base with bits [2:0] forced to zero.
- R9: An acknowledge with no signalled request captures the vector base+7 and sets no in-service bit.
- R10: The slave-select output is high after an acknowledge of the cascade line (line 2 by default) when slave-present is high, and low after any other acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | 8 | Device request lines, rising edge requests |
| slave_present | input | 1 | A slave controller drives the cascade line |
| int_req | output | 1 | Interrupt pending to the processor |
| ack | input | 1 | First acknowledge step: commit winner, capture vector |
| vec_rd | input | 1 | Second step: drive the captured vector |
| vec_out | output | 8 | Captured vector while vec_rd is high, else zero |
| slave_sel | output | 1 | Last acknowledge went to a present slave |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 mask, 1 vector base, 2 end of interrupt |
| wr_data | input | 8 | Write data |

## Verification
The bench targets nesting. A higher-priority line has to break through an active service, and a lower one has to wait. A design that compares against the wrong in-service bound would either miss the nested interrupt or raise the blocked one too early. The bench checks that a line held high stays quiet after its delivery; a level-sensitive latch would retrigger it at once. It checks that end-of-interrupt retires only the top in-service bit; clearing all bits or the wrong bit would release a blocked line early. It also checks that a spurious acknowledge leaves line 7 free; a design that marked line 7 in service would hold it off later.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned PIC_LINES = 8;
  localparam int unsigned IDX_W     = $clog2(PIC_LINES) + 1;
  localparam int unsigned VEC_W     = 8;

  typedef logic [PIC_LINES-1:0] line_vec_t;
  typedef logic [IDX_W-1:0]     line_idx_t;
  typedef logic [VEC_W-1:0]     vector_t;

  // Index of the lowest set bit (highest priority); PIC_LINES when empty.
  function automatic line_idx_t first_set(input line_vec_t v);
    line_idx_t r;
    r = line_idx_t'(PIC_LINES);
    for (int i = PIC_LINES - 1; i >= 0; i--) begin
      if (v[i]) r = line_idx_t'(i);
    end
    return r;
  endfunction

  function automatic line_vec_t idx_onehot(input line_idx_t idx);
    line_vec_t r;
    r = '0;
    for (int i = 0; i < PIC_LINES; i++) begin
      if (idx == line_idx_t'(i)) r[i] = 1'b1;
    end
    return r;
  endfunction

  function automatic vector_t make_vector(input vector_t base, input line_idx_t idx);
    return base + vector_t'(idx);
  endfunction
endpackage

// File: rtl/pic_req_latch.sv
module pic_req_latch
  import pic_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t irq_line,
  input  line_vec_t clr_vec,
  output line_vec_t irr_q
);
  line_vec_t prev_q;
  line_vec_t rise;

  assign rise = irq_line & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= irq_line;
      irr_q  <= (irr_q & ~clr_vec) | rise;
    end
  end

  // R2: a bit can only become set when its line showed a rising edge
  assert_set_needs_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((irr_q & ~$past(irr_q)) & ~$past(rise)) == '0);
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
(
  input  line_vec_t irr_q,
  input  line_vec_t mask_q,
  input  line_vec_t isr_q,
  output line_idx_t grant_idx,
  output logic      grant_valid
);
  line_vec_t pend;
  line_idx_t svc_idx;

  assign pend        = irr_q & ~mask_q;
  assign grant_idx   = first_set(pend);
  assign svc_idx     = first_set(isr_q);
  assign grant_valid = (pend != '0) && (grant_idx < svc_idx);
endmodule

// File: rtl/pic_inservice.sv
module pic_inservice
  import pic_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      set_en,
  input  line_idx_t set_idx,
  input  logic      eoi,
  output line_vec_t isr_q
);
  line_vec_t clr_vec;
  line_vec_t set_vec;

  assign clr_vec = eoi    ? idx_onehot(first_set(isr_q)) : '0;
  assign set_vec = set_en ? idx_onehot(set_idx)          : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= (isr_q & ~clr_vec) | set_vec;
  end

  // R5: an accepted acknowledge leaves its line in service
  assert_ack_sets_isr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> isr_q[$past(set_idx[IDX_W-2:0])]);

  // R7: end of interrupt removes exactly one bit when any is set
  assert_eoi_one_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !set_en) |=> ($countones(isr_q) + (($past(isr_q) != '0) ? 1 : 0))
                         == $countones($past(isr_q)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned CASC_LINE  = 2,
  parameter logic [7:0]  RESET_BASE = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_line,
  input  logic       slave_present,
  output logic       int_req,
  input  logic       ack,
  input  logic       vec_rd,
  output logic [7:0] vec_out,
  output logic       slave_sel,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data
);
  localparam logic [1:0] ADDR_MASK = 2'd0;
  localparam logic [1:0] ADDR_BASE = 2'd1;
  localparam logic [1:0] ADDR_EOI  = 2'd2;

  line_vec_t irr_q, isr_q, mask_q, clr_req;
  vector_t   base_q, vec_q;
  line_idx_t grant_idx;
  logic      grant_valid;
  logic      take_grant, spurious_ack, eoi_pulse;

  assign take_grant   = ack && grant_valid;
  assign spurious_ack = ack && !grant_valid;
  assign eoi_pulse    = wr_en && (wr_addr == ADDR_EOI);
  assign clr_req      = take_grant ? idx_onehot(grant_idx) : '0;

  pic_req_latch u_req (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line),
    .clr_vec(clr_req), .irr_q(irr_q)
  );

  pic_arbiter u_arb (
    .irr_q(irr_q), .mask_q(mask_q), .isr_q(isr_q),
    .grant_idx(grant_idx), .grant_valid(grant_valid)
  );

  pic_inservice u_svc (
    .clk(clk), .rst_n(rst_n), .set_en(take_grant), .set_idx(grant_idx),
    .eoi(eoi_pulse), .isr_q(isr_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '1;
      base_q    <= RESET_BASE;
      vec_q     <= '0;
      slave_sel <= 1'b0;
    end else begin
      if (wr_en && wr_addr == ADDR_MASK) mask_q <= wr_data;
      if (wr_en && wr_addr == ADDR_BASE) base_q <= {wr_data[7:3], 3'b000};
      if (take_grant) begin
        vec_q     <= make_vector(base_q, grant_idx);
        slave_sel <= slave_present && (grant_idx == line_idx_t'(CASC_LINE));
      end else if (spurious_ack) begin
        vec_q     <= make_vector(base_q, line_idx_t'(PIC_LINES - 1));
        slave_sel <= 1'b0;
      end
    end
  end

  assign int_req = grant_valid;
  assign vec_out = vec_rd ? vec_q : '0;

  // R3: the interrupt output needs an unmasked pending request
  assert_int_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ((irr_q & ~mask_q) != '0));

  // R4: vector low bits carry the granted line number
  assert_vec_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_grant |=> vec_q[2:0] == $past(grant_idx[2:0]));

  // R9: spurious acknowledge yields base+7 and leaves service state alone
  assert_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (spurious_ack && !eoi_pulse) |=> (vec_q == $past(base_q) + 8'd7) && $stable(isr_q));

  // R10: slave select only for the cascade line
  assert_slave_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take_grant && grant_idx != line_idx_t'(CASC_LINE) |=> !slave_sel);
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_line = '0;
  logic       slave_present = 1'b0;
  logic       ack = 1'b0, vec_rd = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       int_req, slave_sel;
  logic [7:0] vec_out;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  // behavioural reference state
  bit [7:0] m_irr, m_isr, m_mask, m_base, m_vec, m_prev;
  bit       m_sel;

  always #2 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .slave_present(slave_present),
    .int_req(int_req), .ack(ack), .vec_rd(vec_rd), .vec_out(vec_out),
    .slave_sel(slave_sel), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic int top_bit(bit [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit m_int();
    int p;
    p = top_bit(m_irr & ~m_mask);
    return (p < 8) && (p < top_bit(m_isr));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_irr = 0; m_isr = 0; m_mask = 8'hFF; m_base = 8'h20; m_vec = 0; m_prev = 0; m_sel = 0;
    end else begin
      int p, e;
      bit [7:0] rise;
      rise = irq_line & ~m_prev;
      m_prev = irq_line;
      e = top_bit(m_isr);
      p = top_bit(m_irr & ~m_mask);
      if (ack) begin
        if (m_int()) begin
          m_irr[p] = 0; m_vec = m_base + p[7:0];
          m_sel = slave_present && (p == 2);
        end else begin
          m_vec = m_base + 8'd7; m_sel = 0;
        end
      end
      if (wr_en && wr_addr == 2 && e < 8) m_isr[e] = 0;
      if (ack && p < 8 && p < e) m_isr[p] = 1;
      if (wr_en && wr_addr == 0) m_mask = wr_data;
      if (wr_en && wr_addr == 1) m_base = {wr_data[7:3], 3'b000};
      m_irr = m_irr | rise;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(int_req == m_int(), "R3/R6 int_req vs model", int_req, m_int());
      check(vec_out == (vec_rd ? m_vec : 8'h00), "R4/R9 vec_out vs model", vec_out,
            vec_rd ? m_vec : 8'h00);
      check(slave_sel == m_sel, "R10 slave_sel vs model", slave_sel, m_sel);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; tick(); wr_en = 0;
  endtask

  task automatic do_ack();
    ack = 1; tick(); ack = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        finish_run();
      end
    end
  end

  initial begin
    tick(3); rst_n = 1; tick();
    // R1 reset state
    check(int_req == 0, "R1 int after reset", int_req, 0);
    check(vec_out == 0, "R1 vec gated by vec_rd", vec_out, 0);
    irq_line = 8'h28; tick(2);
    check(int_req == 0, "R1 reset mask blocks lines", int_req, 0);
    // R3 unmask releases held requests
    wr(0, 8'h00); tick();
    check(int_req == 1, "R3 unmask raises int", int_req, 1);
    vec_rd = 1;
    // R4 priority, R5/R6 service blocking
    do_ack();
    check(vec_out == 8'h23, "R4 vector line 3", vec_out, 8'h23);
    check(int_req == 0, "R6 line 5 blocked by service 3", int_req, 0);
    wr(2, 8'h5A);
    check(int_req == 1, "R7 eoi releases line 5", int_req, 1);
    do_ack();
    check(vec_out == 8'h25, "R4 vector line 5", vec_out, 8'h25);
    wr(2, 0); tick(2);
    // R2 level held does not retrigger
    check(int_req == 0, "R2 held line quiet", int_req, 0);
    irq_line = 8'h20; tick(); irq_line = 8'h28; tick();
    check(int_req == 1, "R2 new edge requests", int_req, 1);
    // R6 nesting
    do_ack();
    irq_line = 8'h2A; tick();
    check(int_req == 1, "R6 higher priority nests", int_req, 1);
    do_ack();
    check(vec_out == 8'h21, "R6 nested vector", vec_out, 8'h21);
    irq_line = 8'h00; tick(); irq_line = 8'h10; tick();
    check(int_req == 0, "R6 line 4 below service 3", int_req, 0);
    wr(2, 0);
    check(int_req == 0, "R7 eoi cleared only line 1", int_req, 0);
    wr(2, 0);
    check(int_req == 1, "R7 second eoi frees line 4", int_req, 1);
    // R3 masking a pending request
    wr(0, 8'h10);
    check(int_req == 0, "R3 masked pending", int_req, 0);
    wr(0, 8'h00);
    check(int_req == 1, "R3 still pending after unmask", int_req, 1);
    // R8 base write
    wr(1, 8'h47);
    do_ack();
    check(vec_out == 8'h44, "R8 base low bits zeroed", vec_out, 8'h44);
    wr(2, 0);
    // R9 spurious
    do_ack();
    check(vec_out == 8'h47, "R9 spurious vector", vec_out, 8'h47);
    irq_line = 8'h80; tick();
    check(int_req == 1, "R9 no service bit for line 7", int_req, 1);
    do_ack(); wr(2, 0);
    // R10 cascade
    slave_present = 1; irq_line = 8'h04; tick();
    do_ack();
    check(slave_sel == 1, "R10 slave selected", slave_sel, 1);
    check(vec_out == 8'h42, "R10 cascade vector", vec_out, 8'h42);
    wr(2, 0);
    irq_line = 8'h40; tick(); do_ack();
    check(slave_sel == 0, "R10 other line not slave", slave_sel, 0);
    wr(2, 0);
    slave_present = 0; irq_line = 8'h00; tick(); irq_line = 8'h04; tick(); do_ack();
    check(slave_sel == 0, "R10 slave absent", slave_sel, 0);
    wr(2, 0);
    vec_rd = 0; tick();
    check(vec_out == 0, "R1 vec gated low", vec_out, 0);
    tick(2);
    finish_run();
  end
endmodule